// File: doc/BRIEF.md
# Three-Phase Motor PWM Generator

This block drives three motor phases (U, V, W) from one shared timebase. A 12-bit counter advances on ticks from a 3-bit prescaler and runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each phase compares the counter with its own duty value, which software writes as a high byte and a low byte. All timing-critical settings are written into shadow registers first. They become live together, at one well-defined point in the counter cycle.

The control byte selects the compare resolution, the counter shape and the prescaler divisor. It also holds one force bit per phase. A force bit drives its phase fully on for exactly one counter cycle. Duty bytes, the period and the force and resolution selections move from shadow to live only on the update event. A one-clock `upd_pulse` marks the first cycle in which the new values are in effect. The force bits clear themselves once they have been moved to the live copy.

Top module: `tri_pwm`

## Requirements
- R1: After reset the control byte is 00h, all live values are zero and the period is 0. While reset is held, all three PWM outputs and `upd_pulse` are low. Once reset is released, the block runs edge-aligned with divisor 1, so `upd_pulse` repeats every clock and the outputs stay low.
- R2: Control bits 2..0 hold a prescaler code N. The counter advances once every N+1 clocks.
- R3: With control bit 3 = 0 (edge-aligned), the counter counts 0..P and wraps to 0. P is the live period. The update event is the wrap, so successive `upd_pulse` cycles are (P+1)·(N+1) clocks apart.
- R4: With control bit 3 = 1 (center-aligned), the counter counts up to P and back down to 0. The update event occurs when the down-count leaves zero. Successive `upd_pulse` cycles are 2·P·(N+1) clocks apart for P ≥ 1.
- R5: A phase output is high while the counter value is below that phase's live effective compare value. An effective compare value of 0 gives a constantly low output.
- R6: With control bit 7 = 0 (fine resolution), the effective compare is {high[6:0], low[7:3]}. High-byte bit 7 set means the phase is fully on, and this lasts for as long as it stays in the live copy.
- R7: With control bit 7 = 1 (coarse resolution), the effective compare is high·16. The low byte is ignored.
- R8: Control bits 6, 5 and 4 force phases U, V and W respectively. A forced phase is high for the whole counter cycle that begins at the next update event.
- R9: A force bit clears itself when it is transferred at an update event. The phase returns to its compare-based duty in the cycle after that.
- R10: Duty bytes, the period, the force bits and the resolution bit take effect only at an update event. `upd_pulse` is high for one clock: the first clock in which the new values are live.
- R11: Writes decode as follows. Address 0 is control. Addresses 1/2 are the U high/low bytes, 3/4 are V, and 5/6 are W. Address 7 holds period bits 11..8 in data bits 3..0, and address 8 holds period bits 7..0. Writes to addresses 9..15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_u | output | 1 | Phase U PWM output |
| pwm_v | output | 1 | Phase V PWM output |
| pwm_w | output | 1 | Phase W PWM output |
| upd_pulse | output | 1 | One-clock marker of the first cycle with newly loaded values |

## Verification
The embedded assertions check the following on every cycle: the spacing of prescaler ticks, that the counter holds between ticks, that the counter restarts near zero after an update event, and that live duty and period values change only on an update event. They also check that force bits are copied at the event and then cleared. The bench's sweeps alone show the high-time counts and period lengths for each counter shape, divisor, period and compare value. The same is true of the two resolution encodings, the one-cycle lifetime of a force, the deferred effect of a mid-cycle write, and the register address map.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  localparam int DW  = 8;              // register data width
  localparam int AW  = 4;              // register address width
  localparam int CW  = 12;             // counter / compare width
  localparam int PW  = 3;              // prescaler code width
  localparam int NPH = 3;              // number of phases
  localparam int PER_HI_W   = CW - DW;         // period bits in the upper byte
  localparam int FINE_LO_W  = CW - (DW - 1);   // low-byte bits used in fine mode
  localparam int COARSE_SH  = CW - DW;         // left shift in coarse mode

  localparam logic [AW-1:0] ADR_CTRL  = AW'(0);
  localparam logic [AW-1:0] ADR_PH0   = AW'(1);
  localparam logic [AW-1:0] ADR_PER_H = AW'(1 + 2*NPH);
  localparam logic [AW-1:0] ADR_PER_L = AW'(2 + 2*NPH);

  // bit 7 coarse, bits 6..4 force U/V/W, bit 3 center, bits 2..0 prescaler
  typedef struct packed {
    logic           coarse;
    logic [NPH-1:0] force_full;
    logic           center;
    logic [PW-1:0]  psc;
  } ctrl_t;

  function automatic logic [CW-1:0] eff_cmp(input logic [DW-1:0] hi,
                                            input logic [DW-1:0] lo,
                                            input logic coarse);
    if (coarse) return {hi, {COARSE_SH{1'b0}}};
    return {hi[DW-2:0], lo[DW-1 -: FINE_LO_W]};
  endfunction

  function automatic logic phase_full(input logic [DW-1:0] hi,
                                      input logic forced,
                                      input logic coarse);
    return forced | (~coarse & hi[DW-1]);
  endfunction

  function automatic logic psc_done(input logic [PW-1:0] cnt,
                                    input logic [PW-1:0] code);
    return cnt >= code;
  endfunction
endpackage

// File: rtl/tri_pwm_presc.sv
module tri_pwm_presc
  import tri_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] code,
  output logic          tick
);
  logic [PW-1:0] div_q;

  assign tick = psc_done(div_q, code);

  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (tick)  div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> (!tick || code == '0));
endmodule

// File: rtl/tri_pwm_cnt.sv
module tri_pwm_cnt
  import tri_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          center,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] per_pre,
  output logic [CW-1:0] cnt,
  output logic          upd_evt
);
  logic [CW-1:0] cnt_q;
  logic          dir_dn;
  logic          at_top;
  logic          at_zero;

  assign at_top  = cnt_q >= per_act;
  assign at_zero = cnt_q == '0;
  assign upd_evt = tick & (center ? (dir_dn & at_zero) : at_top);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_dn <= 1'b1;
    end else if (tick) begin
      if (!center) begin
        dir_dn <= 1'b1;
        cnt_q  <= at_top ? '0 : cnt_q + 1'b1;
      end else if (dir_dn) begin
        if (at_zero) begin
          dir_dn <= 1'b0;
          cnt_q  <= (per_pre != '0) ? CW'(1) : '0;
        end else begin
          cnt_q  <= cnt_q - 1'b1;
        end
      end else if (at_top) begin
        dir_dn <= 1'b1;
        cnt_q  <= at_zero ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R3 R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (cnt_q <= CW'(1)));
endmodule

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs
  import tri_pwm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     upd_evt,
  output ctrl_t                    ctrl_q,
  output logic [CW-1:0]            per_act,
  output logic [CW-1:0]            per_pre,
  output logic [NPH-1:0][DW-1:0]   hi_act,
  output logic [NPH-1:0][DW-1:0]   lo_act,
  output logic [NPH-1:0]           force_act,
  output logic                     coarse_act
);
  logic [NPH-1:0][DW-1:0] hi_pre;
  logic [NPH-1:0][DW-1:0] lo_pre;
  logic [PER_HI_W-1:0]    per_hi_q;
  logic [DW-1:0]          per_lo_q;
  logic                   ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign per_pre = {per_hi_q, per_lo_q};

  // shadow registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hi_pre   <= '0;
      lo_pre   <= '0;
      per_hi_q <= '0;
      per_lo_q <= '0;
    end else begin
      if (ctrl_wr)           ctrl_q <= ctrl_t'(wr_data);
      else if (upd_evt)      ctrl_q.force_full <= '0;
      for (int p = 0; p < NPH; p++) begin
        if (wr_en && wr_addr == ADR_PH0 + AW'(2*p))     hi_pre[p] <= wr_data;
        if (wr_en && wr_addr == ADR_PH0 + AW'(2*p + 1)) lo_pre[p] <= wr_data;
      end
      if (wr_en && wr_addr == ADR_PER_H) per_hi_q <= wr_data[PER_HI_W-1:0];
      if (wr_en && wr_addr == ADR_PER_L) per_lo_q <= wr_data;
    end
  end

  // live registers, loaded only at the update event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_act     <= '0;
      lo_act     <= '0;
      per_act    <= '0;
      force_act  <= '0;
      coarse_act <= 1'b0;
    end else if (upd_evt) begin
      hi_act     <= hi_pre;
      lo_act     <= lo_pre;
      per_act    <= per_pre;
      force_act  <= ctrl_q.force_full;
      coarse_act <= ctrl_q.coarse;
    end
  end

  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> ($stable(hi_act) && $stable(lo_act) && $stable(per_act)
                  && $stable(force_act) && $stable(coarse_act)));

  // R8
  force_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (force_act == $past(ctrl_q.force_full)));

  // R9
  self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !ctrl_wr) |=> (ctrl_q.force_full == '0));
endmodule

// File: rtl/tri_pwm_cmp.sv
module tri_pwm_cmp
  import tri_pwm_pkg::*;
(
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic          coarse,
  input  logic          forced,
  output logic          pwm
);
  logic [CW-1:0] thr;
  logic          full;

  assign thr  = eff_cmp(hi, lo, coarse);
  assign full = phase_full(hi, forced, coarse);
  assign pwm  = full | (cnt < thr);
endmodule

// File: rtl/tri_pwm.sv
module tri_pwm
  import tri_pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_u,
  output logic          pwm_v,
  output logic          pwm_w,
  output logic          upd_pulse
);
  ctrl_t                  ctrl_q;
  logic                   tick;
  logic                   upd_evt;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          per_act;
  logic [CW-1:0]          per_pre;
  logic [NPH-1:0][DW-1:0] hi_act;
  logic [NPH-1:0][DW-1:0] lo_act;
  logic [NPH-1:0]         force_act;
  logic                   coarse_act;
  logic [NPH-1:0]         pwm_vec;

  tri_pwm_regs regs_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .upd_evt,
    .ctrl_q, .per_act, .per_pre, .hi_act, .lo_act, .force_act, .coarse_act
  );

  tri_pwm_presc presc_i (
    .clk, .rst_n, .code(ctrl_q.psc), .tick
  );

  tri_pwm_cnt cnt_i (
    .clk, .rst_n, .tick, .center(ctrl_q.center),
    .per_act, .per_pre, .cnt, .upd_evt
  );

  // phase p = 0 is U; its force bit is the most significant one
  for (genvar p = 0; p < NPH; p++) begin : g_phase
    tri_pwm_cmp cmp_i (
      .cnt, .hi(hi_act[p]), .lo(lo_act[p]), .coarse(coarse_act),
      .forced(force_act[NPH-1-p]), .pwm(pwm_vec[p])
    );
  end

  assign pwm_u = pwm_vec[0];
  assign pwm_v = pwm_vec[1];
  assign pwm_w = pwm_vec[2];

  always_ff @(posedge clk) begin
    if (!rst_n) upd_pulse <= 1'b0;
    else        upd_pulse <= upd_evt;
  end

  // R10
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> upd_pulse);
endmodule

// File: tb/tri_pwm_tb.sv
module tri_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_u, pwm_v, pwm_w, upd_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tri_pwm dut_i (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .pwm_u, .pwm_v, .pwm_w, .upd_pulse
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!upd_pulse);
  endtask

  // counts from the current pulse cycle up to the next pulse cycle
  task automatic measure(output int tot, output int hu, output int hv, output int hw);
    tot = 0; hu = 0; hv = 0; hw = 0;
    do begin
      tot++;
      hu += int'(pwm_u); hv += int'(pwm_v); hw += int'(pwm_w);
      @(negedge clk);
      wr_en = 1'b0;
    end while (!upd_pulse);
  endtask

  function automatic int per_len(input bit center, input int per, input int div);
    return center ? 2 * per * div : (per + 1) * div;
  endfunction

  // counter visits: edge 0..P; center 1..P then P-1..0
  function automatic int exp_high(input bit center, input int per, input int c,
                                  input bit full, input int div);
    int n = 0;
    if (full) return per_len(center, per, div);
    if (!center) begin
      for (int v = 0; v <= per; v++) if (v < c) n++;
    end else begin
      for (int v = 1; v <= per; v++) if (v < c) n++;
      for (int v = per - 1; v >= 0; v--) if (v < c) n++;
    end
    return n * div;
  endfunction

  task automatic set_fine(input int ph, input int c);
    wr(1 + 2*ph, (c >> 5) & 8'h7f);
    wr(2 + 2*ph, (c & 31) << 3);
  endtask

  task automatic set_period(input int per);
    wr(7, (per >> 8) & 15);
    wr(8, per & 255);
  endtask

  task automatic run_fine(input bit center, input int per, input int psc,
                          input int cu, input int cv, input int cw);
    int tot, hu, hv, hw, div;
    div = psc + 1;
    set_fine(0, cu); set_fine(1, cv); set_fine(2, cw);
    set_period(per);
    wr(0, (int'(center) << 3) | psc);
    wait_pulse(); wait_pulse();
    measure(tot, hu, hv, hw);
    check(center ? "R4 R2 period" : "R3 R2 period", tot, per_len(center, per, div));
    check("R5 R6 U high", hu, exp_high(center, per, cu, 1'b0, div));
    check("R5 R6 V high", hv, exp_high(center, per, cv, 1'b0, div));
    check("R5 R6 W high", hw, exp_high(center, per, cw, 1'b0, div));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int tot, hu, hv, hw;
    int plist[2] = '{3, 6};
    int slist[3] = '{0, 2, 5};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 outputs held low in reset
    check("R1 outputs in reset", int'({pwm_u, pwm_v, pwm_w, upd_pulse}), 0);
    rst_n = 1'b1;
    wait_pulse();
    measure(tot, hu, hv, hw);
    check("R1 default period", tot, 1);
    check("R1 default outputs", hu + hv + hw, 0);

    // sweep of shapes, periods, divisors and compare values
    for (int cm = 0; cm < 2; cm++)
      foreach (plist[i])
        foreach (slist[j])
          for (int k = 1; k <= plist[i]; k++)
            run_fine(cm[0], plist[i], slist[j], k, k - 1, plist[i] + 1);

    // R7 coarse resolution, low byte ignored
    for (int cm = 0; cm < 2; cm++) begin
      wr(1, 1); wr(2, 8'hf8); wr(3, 2); wr(4, 8'h00); wr(5, 3); wr(6, 8'hff);
      set_period(40);
      wr(0, 8'h80 | (cm << 3));
      wait_pulse(); wait_pulse();
      measure(tot, hu, hv, hw);
      check("R7 period", tot, per_len(cm[0], 40, 1));
      check("R7 U high", hu, exp_high(cm[0], 40, 16, 1'b0, 1));
      check("R7 V high", hv, exp_high(cm[0], 40, 32, 1'b0, 1));
      check("R7 W high", hw, exp_high(cm[0], 40, 48, 1'b0, 1));
    end

    // R6 fine-mode extension bit keeps the phase fully on
    wr(1, 8'h80); wr(2, 0); set_fine(1, 3); set_fine(2, 5);
    set_period(10);
    wr(0, 8'h00);
    wait_pulse(); wait_pulse();
    measure(tot, hu, hv, hw);
    check("R6 ext full first", hu, 11);
    measure(tot, hu, hv, hw);
    check("R6 ext full second", hu, 11);
    check("R6 V normal", hv, 3);

    // R8 force V for one cycle, R9 self-clear afterwards
    set_fine(0, 3); set_fine(1, 5); set_fine(2, 7);
    wait_pulse(); wait_pulse();
    wr(0, 8'h20);
    wait_pulse();
    measure(tot, hu, hv, hw);
    check("R8 forced V", hv, 11);
    check("R8 U unaffected", hu, 3);
    check("R8 W unaffected", hw, 7);
    measure(tot, hu, hv, hw);
    check("R9 V after clear", hv, 5);

    // R10 compare write mid-cycle deferred to next update
    set_period(20);
    set_fine(0, 4);
    wait_pulse(); wait_pulse();
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'(9 << 3);
    measure(tot, hu, hv, hw);
    check("R10 old compare kept", hu, 4);
    measure(tot, hu, hv, hw);
    check("R10 new compare live", hu, 9);

    // R10 period write mid-cycle deferred
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'd12;
    measure(tot, hu, hv, hw);
    check("R10 old period kept", tot, 21);
    measure(tot, hu, hv, hw);
    check("R10 new period live", tot, 13);

    // R11 unmapped addresses have no effect
    for (int a = 9; a < 16; a++) wr(a, 8'hff);
    wait_pulse(); wait_pulse();
    measure(tot, hu, hv, hw);
    check("R11 period unchanged", tot, 13);
    check("R11 U unchanged", hu, 9);
    check("R11 V unchanged", hv, 5);
    check("R11 W unchanged", hw, 7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule